// File: doc/BRIEF.md
# Horizontal Sync Conditioner

This block sits at the front of a video capture path and runs on the pixel clock. It takes a raw horizontal sync line whose active level is not known in advance and works out that level on its own. It does this by measuring how long the line spends high and how long it spends low over each line period. From every active-going edge it builds a clean output pulse. The width of that pulse, in pixel clocks, and its output polarity both come from configuration. The pulse leaves the block from a register clocked in the output data domain, so it keeps a fixed phase to the captured pixels.

The block also feeds a sync reference to an external clock generator. During the vertical sync interval the sync line may carry equalization pulses, gaps or extra edges, so a coast window taken from the vertical sync input holds that reference at its idle level and lets the generator free-run. Systems with a continuous, clean horizontal sync can switch coasting off.

Top module: `hsync_conditioner`

## Requirements
- R1: The active level of `hsync_in` is detected automatically. An output pulse starts on the active-going edge for either input polarity. The first active `hs_out` sample is the third clock after the edge is presented.
- R2: With `cfg_hs_pol_high`=1 the active level of `hs_out` is 1. With it at 0 the active level is 0. The idle level is always the opposite.
- R3: An output pulse lasts exactly `cfg_width` clocks (8-bit, 1..255). A programmed width of 0 gives a 1-clock pulse.
- R4: While an output pulse is in progress, further input edges neither restart it nor lengthen it.
- R5: The polarity is decided once per line, at each rising edge of the synchronized input. The level held for fewer cycles is taken as active, and a tie counts as active low. No output pulse appears before the first full line after reset has been measured, so the first line after reset yields no pulse.
- R6: While `rst_n` is low, `hs_out` is at its idle level, `coast` is 0 and `pll_ref` is 1 (the default decision is active low).
- R7: When coast is inactive, `pll_ref` repeats `hsync_in` in its input polarity, delayed by three clocks.
- R8: With `cfg_coast_en`=1 and `vsync_in` at its active level (1 if `cfg_vs_pol_high`=1, else 0), `coast` is 1 and `pll_ref` stays at the idle level of the detected polarity. Both take effect three clocks after the `vsync_in` change, and both clear the same way.
- R9: With `cfg_coast_en`=0, `coast` stays 0 and `pll_ref` passes the sync through whatever `vsync_in` does.
- R10: Coasting has no effect on `hs_out` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Raw horizontal sync, either polarity |
| vsync_in | input | 1 | Vertical sync used to open the coast window |
| cfg_hs_pol_high | input | 1 | Output sync polarity: 1 active high, 0 active low |
| cfg_width | input | 8 | Output pulse width in pixel clocks (0 acts as 1) |
| cfg_coast_en | input | 1 | Enables coast generation |
| cfg_vs_pol_high | input | 1 | Active level of vsync_in: 1 high, 0 low |
| hs_out | output | 1 | Regenerated horizontal sync |
| pll_ref | output | 1 | Sync reference to the clock generator, masked while coasting |
| coast | output | 1 | High while the reference is masked |

## Verification
Each input is presented at a falling clock edge. The two-flop synchronizer and one output register put every result three rising edges later: the first active `hs_out` sample, the first active `pll_ref` sample and a change of `coast`. Every output is sampled at falling edges only. Each line is measured by recording, per line, the sample index of the first active output and the number of active samples, and these are compared with index 3, the programmed width and the sync length. Before each coast change the bench drives three idle cycles, so the whole measured line lies inside or outside the window.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;
endpackage

// File: rtl/hsc_sync.sv
// Multi-stage synchronizer for N independent single-bit inputs (STAGES >= 2).
module hsc_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg_q, stg_n;

  always_comb begin
    stg_n = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hsc_pol_detect.sv
// Measures high and low time of the synchronized sync over each line
// (rising edge to rising edge) and decides which level is active.
module hsc_pol_detect
  import hsc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_s,
  output pol_e pol,
  output logic valid,
  output logic rise,
  output logic fall
);
  logic             hs_d_q;
  logic [CNT_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic             started_q, started_n;
  pol_e             pol_q, pol_n;
  logic             valid_q, valid_n;

  assign rise = hs_s & ~hs_d_q;
  assign fall = ~hs_s & hs_d_q;

  always_comb begin
    hi_n      = hi_q;
    lo_n      = lo_q;
    started_n = started_q;
    pol_n     = pol_q;
    valid_n   = valid_q;
    if (rise) begin
      if (started_q) begin
        pol_n   = (hi_q < lo_q) ? POL_HIGH : POL_LOW;
        valid_n = 1'b1;
      end
      started_n = 1'b1;
      hi_n      = CNT_W'(1);
      lo_n      = '0;
    end else if (hs_s) begin
      if (hi_q != '1) hi_n = hi_q + 1'b1;
    end else begin
      if (lo_q != '1) lo_n = lo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_d_q    <= 1'b0;
      hi_q      <= '0;
      lo_q      <= '0;
      started_q <= 1'b0;
      pol_q     <= POL_LOW;
      valid_q   <= 1'b0;
    end else begin
      hs_d_q    <= hs_s;
      hi_q      <= hi_n;
      lo_q      <= lo_n;
      started_q <= started_n;
      pol_q     <= pol_n;
      valid_q   <= valid_n;
    end
  end

  assign pol   = pol_q;
  assign valid = valid_q;

  // R5
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

  // R5
  line_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && started_q) |=> valid_q);
endmodule

// File: rtl/hsc_pulse_gen.sv
// Regenerates a fixed-width sync pulse from the detected active edge.
module hsc_pulse_gen
  import hsc_pkg::*;
#(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  pol_e             pol,
  input  logic             rise,
  input  logic             fall,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_hs_pol_high,
  output logic             hs_out
);
  logic [WID_W-1:0] eff_w;
  logic [WID_W-1:0] cnt_q, cnt_n;
  logic             act_q, act_n;
  logic             fire;

  assign eff_w = (cfg_width == '0) ? WID_W'(1) : cfg_width;
  assign fire  = valid & ~act_q & ((pol == POL_HIGH) ? rise : fall);

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (fire) begin
      cnt_n = eff_w - 1'b1;
      act_n = 1'b1;
    end else if (act_q) begin
      if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
      else             act_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign hs_out = cfg_hs_pol_high ? act_q : ~act_q;

  // R3
  width_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (act_q && (cnt_q == $past(eff_w) - 1'b1)));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q != '0) |=> (act_q && cnt_q == $past(cnt_q) - 1'b1));

  // R5
  quiet_before_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !act_q);
endmodule

// File: rtl/hsc_coast.sv
// Coast window from vertical sync; masks the clock-generator reference.
module hsc_coast
  import hsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hs_s,
  input  logic vs_s,
  input  pol_e pol,
  input  logic cfg_coast_en,
  input  logic cfg_vs_pol_high,
  output logic coast,
  output logic pll_ref
);
  logic vs_act;
  logic coast_q, coast_n;
  logic ref_q, ref_n;

  assign vs_act = cfg_vs_pol_high ? vs_s : ~vs_s;

  always_comb begin
    coast_n = cfg_coast_en & vs_act;
    ref_n   = coast_n ? (pol == POL_LOW) : hs_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coast_q <= 1'b0;
      ref_q   <= 1'b1;
    end else begin
      coast_q <= coast_n;
      ref_q   <= ref_n;
    end
  end

  assign coast   = coast_q;
  assign pll_ref = ref_q;

  // R8
  ref_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coast_q |-> (ref_q == ($past(pol) == POL_LOW)));

  // R9
  coast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_coast_en |=> !coast_q);
endmodule

// File: rtl/hsync_conditioner.sv
module hsync_conditioner
  import hsc_pkg::*;
#(
  parameter int WID_W  = 8,
  parameter int CNT_W  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             cfg_hs_pol_high,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_coast_en,
  input  logic             cfg_vs_pol_high,
  output logic             hs_out,
  output logic             pll_ref,
  output logic             coast
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] raw, synced;
  logic             hs_s, vs_s;
  pol_e             pol;
  logic             valid, rise, fall;

  assign raw  = {vsync_in, hsync_in};
  assign hs_s = synced[0];
  assign vs_s = synced[1];

  hsc_sync #(.N(NSYNC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  hsc_pol_detect #(.CNT_W(CNT_W)) u_pol (
    .clk(clk), .rst_n(rst_n), .hs_s(hs_s),
    .pol(pol), .valid(valid), .rise(rise), .fall(fall)
  );

  hsc_pulse_gen #(.WID_W(WID_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .valid(valid), .pol(pol),
    .rise(rise), .fall(fall), .cfg_width(cfg_width),
    .cfg_hs_pol_high(cfg_hs_pol_high), .hs_out(hs_out)
  );

  hsc_coast u_coast (
    .clk(clk), .rst_n(rst_n), .hs_s(hs_s), .vs_s(vs_s), .pol(pol),
    .cfg_coast_en(cfg_coast_en), .cfg_vs_pol_high(cfg_vs_pol_high),
    .coast(coast), .pll_ref(pll_ref)
  );
endmodule

// File: tb/tb_hsync_conditioner.sv
module tb_hsync_conditioner;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hsync_in, vsync_in;
  logic       cfg_hs_pol_high, cfg_coast_en, cfg_vs_pol_high;
  logic [7:0] cfg_width;
  logic       hs_out, pll_ref, coast;

  int nvec  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  hsync_conditioner dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .cfg_hs_pol_high(cfg_hs_pol_high), .cfg_width(cfg_width),
    .cfg_coast_en(cfg_coast_en), .cfg_vs_pol_high(cfg_vs_pol_high),
    .hs_out(hs_out), .pll_ref(pll_ref), .coast(coast)
  );

  // fields: input active high, output active high, width, line length, sync length
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{1, 1,   8,  64,  6},
    '{0, 1,   8,  64,  6},
    '{1, 0,  20, 100, 10},
    '{0, 0,   1,  40,  4},
    '{0, 1,   0,  40,  4},
    '{1, 1, 255, 300, 12}
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit in_high);
    @(negedge clk);
    rst_n    = 1'b0;
    hsync_in = ~in_high;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n, input bit in_high);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync_in = ~in_high;
    end
  endtask

  task automatic run_line(input int per, input int slen, input bit in_high,
                          input bit out_high, input bit glitch,
                          output int hf, output int hc, output int pf,
                          output int pc, output int cc);
    hf = -1; hc = 0; pf = -1; pc = 0; cc = 0;
    for (int i = 0; i < per; i++) begin
      bit lvl;
      @(negedge clk);
      if (hs_out == out_high) begin if (hc == 0) hf = i; hc++; end
      if (pll_ref == in_high) begin if (pc == 0) pf = i; pc++; end
      if (coast) cc++;
      lvl = (i < slen) && !(glitch && i == 1);
      hsync_in = in_high ? lvl : ~lvl;
    end
  endtask

  initial begin
    #(8 * 150000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int hf, hc, pf, pc, cc;
    rst_n = 1'b0; hsync_in = 1'b0; vsync_in = 1'b1;
    cfg_hs_pol_high = 1'b1; cfg_width = 8'd4; cfg_coast_en = 1'b0;
    cfg_vs_pol_high = 1'b0;

    // R6 reset state, both output polarities
    repeat (2) @(negedge clk);
    chk("R6 hs_out idle (high pol)", hs_out, 0);
    chk("R6 coast", coast, 0);
    chk("R6 pll_ref", pll_ref, 1);
    cfg_hs_pol_high = 1'b0;
    @(negedge clk);
    chk("R6 hs_out idle (low pol)", hs_out, 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      bit ih, oh;
      int w, per, sl, effw;
      ih = VEC[v][0][0]; oh = VEC[v][1][0];
      w = VEC[v][2]; per = VEC[v][3]; sl = VEC[v][4];
      effw = (w == 0) ? 1 : w;
      cfg_hs_pol_high = oh; cfg_width = 8'(w); cfg_coast_en = 1'b0;
      do_reset(ih);
      run_line(per, sl, ih, oh, 1'b0, hf, hc, pf, pc, cc);
      chk("R5 no pulse in first line", hc, 0);
      run_line(per, sl, ih, oh, 1'b0, hf, hc, pf, pc, cc);
      run_line(per, sl, ih, oh, 1'b0, hf, hc, pf, pc, cc);
      chk("R1 pulse start offset", hf, 3);
      chk("R3 pulse width", hc, effw);
      chk("R7 pll_ref length", pc, sl);
      chk("R7 pll_ref offset", pf, 3);
      @(negedge clk);
      chk("R2 idle level after pulse", hs_out, oh ? 0 : 1);
    end

    // R4 extra edge during a pulse
    cfg_hs_pol_high = 1'b1; cfg_width = 8'd10;
    do_reset(1'b1);
    run_line(64, 5, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    run_line(64, 5, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    run_line(64, 5, 1'b1, 1'b1, 1'b1, hf, hc, pf, pc, cc);
    chk("R4 glitch start", hf, 3);
    chk("R4 glitch width", hc, 10);

    // coast behaviour, vsync active low
    cfg_width = 8'd4; cfg_coast_en = 1'b1; cfg_vs_pol_high = 1'b0;
    vsync_in = 1'b1;
    do_reset(1'b1);
    repeat (3) run_line(40, 4, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    chk("R8 coast idle outside vsync", cc, 0);
    vsync_in = 1'b0;
    idle(3, 1'b1);
    run_line(40, 4, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    chk("R8 coast asserted", cc, 40);
    chk("R8 pll_ref masked", pc, 0);
    chk("R10 hs_out unaffected width", hc, 4);
    chk("R10 hs_out unaffected offset", hf, 3);
    vsync_in = 1'b1;
    idle(3, 1'b1);
    run_line(40, 4, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    chk("R8 coast released", cc, 0);
    chk("R8 pll_ref restored", pc, 4);
    cfg_coast_en = 1'b0; vsync_in = 1'b0;
    idle(3, 1'b1);
    run_line(40, 4, 1'b1, 1'b1, 1'b0, hf, hc, pf, pc, cc);
    chk("R9 coast disabled", cc, 0);
    chk("R9 pll_ref passes", pc, 4);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule